// File: doc/BRIEF.md
# Four-Rail Power Sequencer Controller

This controller brings four supply rails up one after another and takes them down in the opposite order. Each rail has an active-high enable output and a filtered "rail above its undervoltage threshold" input. A rising edge on the up request, seen while the block idles in wait-start, starts power-up. Before each enable is raised, that channel's programmed delay runs. After the enable is raised, the rail must report good within a shared blanking window. When the fourth rail reports good, the sequence-complete output goes high. A falling edge on the down request in the power-up-done state starts power-down. Power-down reuses the same per-channel delays in reverse and applies no blanking check.

A bidirectional active-low fault line ties several controllers together. An open-drain pin is modelled as two signals: a drive-low enable output and a sampled line input. Any internal fault pulls the line low, and a low line that the block is not driving forces it into its own fault handler. The fault handler turns off every enable and holds the fault for a fixed number of cycles. It returns to wait-start once the line is free and the up request is low. The power-good output is the AND of the four rail inputs and does not depend on the state machine. All delays, the blanking window and the fault hold are counts of clock cycles. The inputs are assumed to be deglitched and synchronised upstream.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset all enables are low, sequence-complete is low, the fault drive is off and the block is in wait-start.
- R2: In wait-start, an up request that is high at a clock edge after being low at the previous edge starts power-up. Enable 1 (bit 0 of `en_o`) goes high D1+1 edges later, where D1 is field 0 of `dly_i` (bits DW-1:0).
- R3: For N = 2..4, enable N (bit N-1) goes high DN+1 edges after the edge at which rail N-1 is first sampled good. DN is field N-1 of `dly_i`. An enable is never high unless every lower-numbered enable is high.
- R4: After an enable goes high, its rail is sampled at each of the next B+1 edges, where B is `blank_i`. If the rail is low at all of them, the block enters the fault state at the last of those edges.
- R5: A falling edge on the down request in power-up-done clears enable 4 at that edge. Enable 3 then clears D4+1 edges later, enable 2 D3+1 edges after that, and enable 1 D2+1 edges after that. Sequence-complete clears D1+1 edges after enable 1, and wait-start follows one edge later.
- R6: Sequence-complete goes high at the edge where rail 4 is first sampled good, and at that moment all four enables are high.
- R7: A rail that has already been confirmed good and reads low, during power-up or power-up-done, causes a fault at the next edge. The fault clears all enables and sequence-complete and raises the fault drive. The fault drive never rises while any enable stays high.
- R8: A falling edge on either request during power-up is a fault. So is a falling up request in power-up-done, and a rising edge on either request during power-down.
- R9: A low fault line while the block is not driving it, outside the fault state, causes a fault at the next edge.
- R10: The fault drive stays on for exactly HOLD_CYC+1 cycles. The block returns to wait-start only when the hold has expired, the line reads high and the up request is low. A fresh rising up edge is needed after that.
- R11: `pgood_o` is high exactly when all four rail inputs are high, in every state.
- R12: A falling down request in wait-start has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_ok_i | input | NCH | Per-rail above-threshold flags, bit 0 is rail 1 |
| up_req_i | input | 1 | Power-up request, rising edge triggers |
| dn_req_i | input | 1 | Power-down request, falling edge triggers |
| flt_n_i | input | 1 | Sampled level of the shared active-low fault line |
| dly_i | input | NCH*DW | Per-channel delays in cycles, field k is channel k+1 |
| blank_i | input | DW | Blanking window in cycles |
| en_o | output | NCH | Rail enables, bit 0 is rail 1 |
| pgood_o | output | 1 | All rails above threshold |
| seq_done_o | output | 1 | Power-up sequence complete |
| flt_drv_o | output | 1 | Pull the fault line low |

## Verification
The bench builds the block with NCH=4, DW=8 and HOLD_CYC=6. With the hold that short, the whole fault-hold window, its release, and a held external pull that blocks re-entry to wait-start all fit inside a few tens of cycles. Two delay sets are used, one containing a zero delay, so the D+1 edge counts are checked at their smallest values and in both orders. The blanking window of four cycles allows both a rail that comes good on the last sampling edge and one that never comes good.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_ON_WAIT  = 3'd1,
    S_ON_CHECK = 3'd2,
    S_RUN      = 3'd3,
    S_OFF_WAIT = 3'd4,
    S_OFF_DONE = 3'd5,
    S_FAULT    = 3'd6
  } seq_state_t;
endpackage

// File: rtl/pseq_edge.sv
module pseq_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end

  assign rise = d & ~q;
  assign fall = ~d & q;
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pseq_fault.sv
module pseq_fault
  import pwr_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  seq_state_t     st,
  input  logic [NCH-1:0] rail_ok,
  input  logic [NCH-1:0] ok_mask,
  input  logic           up_rise,
  input  logic           up_fall,
  input  logic           dn_rise,
  input  logic           dn_fall,
  input  logic           flt_line_n,
  input  logic           flt_drv_q,
  input  logic           blank_expired,
  output logic           fault_now
);
  logic in_up, in_dn, uv, ctl, ext;

  always_comb begin
    in_up = (st == S_ON_WAIT) || (st == S_ON_CHECK);
    in_dn = (st == S_OFF_WAIT) || (st == S_OFF_DONE);
    uv    = (in_up || st == S_RUN) && |(ok_mask & ~rail_ok);
    ctl   = (in_up && (up_fall || dn_fall))
          || (st == S_RUN && up_fall)
          || (in_dn && (up_rise || dn_rise));
    ext   = ~flt_line_n & ~flt_drv_q;
    fault_now = (st != S_FAULT) && (uv || ctl || ext || blank_expired);
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int HOLD_CYC = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    rail_ok_i,
  input  logic              up_req_i,
  input  logic              dn_req_i,
  input  logic              flt_n_i,
  input  logic [NCH*DW-1:0] dly_i,
  input  logic [DW-1:0]     blank_i,
  output logic [NCH-1:0]    en_o,
  output logic              pgood_o,
  output logic              seq_done_o,
  output logic              flt_drv_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HW   = $clog2(HOLD_CYC + 1);
  localparam int TW   = (DW > HW) ? DW : HW;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  seq_state_t     st_q, st_n;
  logic [CH_W-1:0] ch_q, ch_n, ch_up, ch_dn;
  logic [NCH-1:0] en_q, en_n, mask_q, mask_n;
  logic           done_q, done_n, drv_q, drv_n;
  logic           t_load, t_dec, t_zero;
  logic [TW-1:0]  t_val;
  logic           up_rise, up_fall, dn_rise, dn_fall;
  logic           blank_to, fault_now;
  logic [DW-1:0]  dly_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_dly
    assign dly_a[g] = dly_i[g*DW +: DW];
  end

  pseq_edge #(.RST_VAL(1'b1)) u_up_edge (
    .clk(clk), .rst_n(rst_n), .d(up_req_i), .rise(up_rise), .fall(up_fall)
  );

  pseq_edge #(.RST_VAL(1'b0)) u_dn_edge (
    .clk(clk), .rst_n(rst_n), .d(dn_req_i), .rise(dn_rise), .fall(dn_fall)
  );

  pseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  assign blank_to = (st_q == S_ON_CHECK) && !rail_ok_i[ch_q] && t_zero;

  pseq_fault #(.NCH(NCH)) u_fault (
    .st(st_q), .rail_ok(rail_ok_i), .ok_mask(mask_q),
    .up_rise(up_rise), .up_fall(up_fall), .dn_rise(dn_rise), .dn_fall(dn_fall),
    .flt_line_n(flt_n_i), .flt_drv_q(drv_q), .blank_expired(blank_to),
    .fault_now(fault_now)
  );

  assign ch_up = ch_q + CH_W'(1);
  assign ch_dn = ch_q - CH_W'(1);

  always_comb begin
    st_n   = st_q;
    ch_n   = ch_q;
    en_n   = en_q;
    mask_n = mask_q;
    done_n = done_q;
    drv_n  = drv_q;
    t_load = 1'b0;
    t_dec  = 1'b0;
    t_val  = '0;
    case (st_q)
      S_IDLE: begin
        if (up_rise) begin
          st_n   = S_ON_WAIT;
          ch_n   = '0;
          t_load = 1'b1;
          t_val  = TW'(dly_a[0]);
        end
      end
      S_ON_WAIT: begin
        if (t_zero) begin
          en_n[ch_q] = 1'b1;
          st_n       = S_ON_CHECK;
          t_load     = 1'b1;
          t_val      = TW'(blank_i);
        end else begin
          t_dec = 1'b1;
        end
      end
      S_ON_CHECK: begin
        if (rail_ok_i[ch_q]) begin
          mask_n[ch_q] = 1'b1;
          if (ch_q == LAST_CH) begin
            st_n   = S_RUN;
            done_n = 1'b1;
          end else begin
            ch_n   = ch_up;
            st_n   = S_ON_WAIT;
            t_load = 1'b1;
            t_val  = TW'(dly_a[ch_up]);
          end
        end else begin
          t_dec = 1'b1;
        end
      end
      S_RUN: begin
        if (dn_fall) begin
          en_n[NCH-1] = 1'b0;
          mask_n      = '0;
          ch_n        = LAST_CH;
          st_n        = S_OFF_WAIT;
          t_load      = 1'b1;
          t_val       = TW'(dly_a[NCH-1]);
        end
      end
      S_OFF_WAIT: begin
        if (t_zero) begin
          if (ch_q == '0) begin
            done_n = 1'b0;
            st_n   = S_OFF_DONE;
          end else begin
            en_n[ch_dn] = 1'b0;
            ch_n        = ch_dn;
            t_load      = 1'b1;
            t_val       = TW'(dly_a[ch_dn]);
          end
        end else begin
          t_dec = 1'b1;
        end
      end
      S_OFF_DONE: st_n = S_IDLE;
      S_FAULT: begin
        if (!t_zero) t_dec = 1'b1;
        else         drv_n = 1'b0;
        if (t_zero && !drv_q && flt_n_i && !up_req_i) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase

    if (fault_now) begin
      st_n   = S_FAULT;
      ch_n   = '0;
      en_n   = '0;
      mask_n = '0;
      done_n = 1'b0;
      drv_n  = 1'b1;
      t_load = 1'b1;
      t_dec  = 1'b0;
      t_val  = TW'(HOLD_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ch_q   <= '0;
      en_q   <= '0;
      mask_q <= '0;
      done_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ch_q   <= ch_n;
      en_q   <= en_n;
      mask_q <= mask_n;
      done_q <= done_n;
      drv_q  <= drv_n;
    end
  end

  assign en_o       = en_q;
  assign seq_done_o = done_q;
  assign flt_drv_o  = drv_q;
  assign pgood_o    = &rail_ok_i;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
  import pwr_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] en_o,
  input logic           seq_done_o,
  input logic           flt_drv_o,
  input logic           flt_n_i,
  input seq_state_t     st_i
);
  for (genvar i = 1; i < NCH; i++) begin : g_order
    assert_en_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_o[i] |-> en_o[i-1]);
  end

  assert_en_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o != $past(en_o) && en_o != '0) |-> $countones(en_o ^ $past(en_o)) == 1);

  assert_done_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done_o) |-> &en_o);

  assert_done_drop_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(seq_done_o) && !flt_drv_o) |-> en_o == '0);

  assert_fault_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_drv_o) |-> (en_o == '0 && !seq_done_o));

  assert_ext_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i != S_FAULT && !flt_n_i && !flt_drv_o) |=> (flt_drv_o && en_o == '0));

  assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_drv_o) |-> (en_o == '0 && st_i == S_FAULT));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_o(en_o), .seq_done_o(seq_done_o),
  .flt_drv_o(flt_drv_o), .flt_n_i(flt_n_i), .st_i(st_q)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int HOLD = 6;
  localparam int BLANK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] rail_ok = '0;
  logic up_req = 1'b0;
  logic dn_req = 1'b1;
  logic ext_pull = 1'b0;
  logic flt_line;
  logic [NCH*DW-1:0] dly = '0;
  logic [DW-1:0] blank = DW'(BLANK);
  logic [NCH-1:0] en;
  logic pgood, seq_done, flt_drv;
  int checks = 0;
  int errors = 0;
  int dl [NCH];

  assign flt_line = ~(flt_drv | ext_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.NCH(NCH), .DW(DW), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .rail_ok_i(rail_ok), .up_req_i(up_req),
    .dn_req_i(dn_req), .flt_n_i(flt_line), .dly_i(dly), .blank_i(blank),
    .en_o(en), .pgood_o(pgood), .seq_done_o(seq_done), .flt_drv_o(flt_drv)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic sig(input int sel);
    if (sel < NCH) return en[sel];
    if (sel == NCH) return seq_done;
    return flt_drv;
  endfunction

  task automatic wait_sig(input int sel, input logic val, output int k);
    k = 0;
    do begin
      tick();
      k++;
    end while (sig(sel) != val && k < 300);
  endtask

  task automatic set_delays(input int a, input int b, input int c, input int d);
    dl[0] = a; dl[1] = b; dl[2] = c; dl[3] = d;
    dly = {DW'(d), DW'(c), DW'(b), DW'(a)};
  endtask

  task automatic recover();
    int k;
    up_req = 1'b0;
    rail_ok = '0;
    ext_pull = 1'b0;
    wait_sig(NCH + 1, 1'b0, k);
    repeat (3) tick();
  endtask

  // full power-up; late_ch gets its rail raised on the last blanking edge
  task automatic t_power_up(input int late_ch);
    int k;
    up_req = 1'b1;
    wait_sig(0, 1'b1, k);
    check("R2 enable 1 delay", k, dl[0] + 2);
    for (int i = 0; i < NCH; i++) begin
      if (i == late_ch) repeat (BLANK) tick();
      rail_ok[i] = 1'b1;
      if (i < NCH - 1) begin
        wait_sig(i + 1, 1'b1, k);
        check("R3 next enable delay", k, dl[i+1] + 2);
      end else begin
        wait_sig(NCH, 1'b1, k);
        check("R6 sequence done edge", k, 1);
        check("R6 all enables on", int'(en), 15);
        check("R11 pgood all good", int'(pgood), 1);
        check("R4 no fault on late rail", int'(flt_drv), 0);
      end
    end
  endtask

  task automatic t_power_down();
    int k;
    dn_req = 1'b0;
    wait_sig(3, 1'b0, k);
    check("R5 enable 4 drop", k, 1);
    rail_ok[3] = 1'b0;
    for (int i = 2; i >= 0; i--) begin
      wait_sig(i, 1'b0, k);
      check("R5 reverse enable drop", k, dl[i+1] + 1);
      rail_ok[i] = 1'b0;
    end
    wait_sig(NCH, 1'b0, k);
    check("R5 sequence done drop", k, dl[0] + 1);
    check("R5 no fault in power-down", int'(flt_drv), 0);
    up_req = 1'b0;
    repeat (2) tick();
    dn_req = 1'b1;
    repeat (2) tick();
  endtask

  task automatic t_reset();
    check("R1 enables low", int'(en), 0);
    check("R1 done low", int'(seq_done), 0);
    check("R1 fault drive off", int'(flt_drv), 0);
  endtask

  task automatic t_pgood();
    rail_ok = 4'b1111; #1;
    check("R11 pgood high", int'(pgood), 1);
    rail_ok = 4'b1011; #1;
    check("R11 pgood low", int'(pgood), 0);
    rail_ok = 4'b0000;
    tick();
  endtask

  task automatic t_dn_idle();
    dn_req = 1'b0;
    repeat (4) tick();
    check("R12 enables unchanged", int'(en), 0);
    check("R12 done unchanged", int'(seq_done), 0);
    check("R12 no fault", int'(flt_drv), 0);
    dn_req = 1'b1;
    repeat (2) tick();
  endtask

  task automatic t_blank_timeout();
    int k;
    up_req = 1'b1;
    wait_sig(0, 1'b1, k);
    rail_ok[0] = 1'b1;
    wait_sig(1, 1'b1, k);
    wait_sig(NCH + 1, 1'b1, k);
    check("R4 blanking timeout edge", k, BLANK + 1);
    check("R7 enables off on fault", int'(en), 0);
    recover();
  endtask

  task automatic t_uv_hold();
    int cnt;
    t_power_up(-1);
    rail_ok[1] = 1'b0;
    up_req = 1'b0;
    tick();
    check("R8 up fall in done is fault", int'(flt_drv), 1);
    check("R7 enables off", int'(en), 0);
    check("R7 done cleared", int'(seq_done), 0);
    rail_ok = '0;
    cnt = 0;
    while (flt_drv && cnt < 100) begin
      cnt++;
      tick();
    end
    check("R10 hold length", cnt, HOLD + 1);
    repeat (2) tick();
  endtask

  task automatic t_uv_only();
    t_power_up(-1);
    rail_ok[2] = 1'b0;
    tick();
    check("R7 undervoltage fault", int'(flt_drv), 1);
    check("R7 enables off uv", int'(en), 0);
    recover();
  endtask

  task automatic t_ctl_fault();
    up_req = 1'b1;
    repeat (2) tick();
    up_req = 1'b0;
    tick();
    check("R8 up fall during power-up", int'(flt_drv), 1);
    recover();
  endtask

  task automatic t_ext_fault();
    int k;
    up_req = 1'b1;
    wait_sig(0, 1'b1, k);
    rail_ok[0] = 1'b1;
    ext_pull = 1'b1;
    tick();
    check("R9 external fault drive", int'(flt_drv), 1);
    check("R9 enables off", int'(en), 0);
    up_req = 1'b0;
    rail_ok = '0;
    repeat (HOLD + 6) tick();
    check("R10 drive released", int'(flt_drv), 0);
    up_req = 1'b1;
    repeat (dl[0] + 4) tick();
    check("R10 held line blocks start", int'(en), 0);
    up_req = 1'b0;
    tick();
    ext_pull = 1'b0;
    repeat (3) tick();
    up_req = 1'b1;
    wait_sig(0, 1'b1, k);
    check("R10 restart after release", k, dl[0] + 2);
    rail_ok[0] = 1'b1;
    dn_req = 1'b0;
    tick();
    check("R8 dn fall during power-up", int'(flt_drv), 1);
    dn_req = 1'b1;
    recover();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_delays(2, 3, 1, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pgood();
    t_dn_idle();
    t_power_up(2);
    t_power_down();
    set_delays(0, 5, 2, 4);
    t_power_up(-1);
    t_power_down();
    t_blank_timeout();
    t_uv_hold();
    t_uv_only();
    t_ctl_fault();
    t_ext_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule